// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a bus-mapped watchdog for a small system-on-chip. A 16-bit counter steps forward on prescaled ticks of one of three tick sources. When the counter reaches a programmed limit, the block asks for a system reset. The tick sources arrive as single-cycle enable strobes that are already in the bus clock domain. A control word chooses which strobes count and sets a power-of-four divide ratio. Software keeps the system alive by writing zero into the counter before it reaches the limit.

Four word-aligned registers sit on a simple synchronous bus. Writes carry byte strobes, and reads are combinational from the address. To set the block up, software works in this order:

1. Stop the counter.
2. Write the divide code with no source selected.
3. Set the limit.
4. Zero the counter.
5. Write the divide code with a source selected.
6. Start the counter.

Top module: `wdg_top`

## Requirements
- R1: A synchronous reset clears the limit, enable, counter and control registers to zero and holds `wdg_rst_req` low.
- R2: The registers sit at these word offsets: 0x0 is the 16-bit limit, 0x4 is the run flag in bit 0, 0x8 is the 16-bit counter and 0xC is the control word. Each register reads back its value, unused bits read as zero, and any other address reads as zero and ignores writes.
- R3: Byte strobe `bus_be[0]` writes bits 7:0 and `bus_be[1]` writes bits 15:8. Bytes whose strobe is low keep their old value.
- R4: Control bits [2:0] are a source mask. Bit k lets `tick_src[k]` count. A strobe whose bit is clear has no effect, and with no bit set the counter never moves.
- R5: Control bits [5:3] are the divide code c. One counter step needs 4^c selected ticks for c from 0 to 5, and codes 6 and 7 divide by 1024. The counter therefore reaches limit L after L·ratio selected ticks.
- R6: Any write to the control or run-flag register clears the internal divider, so partial tick counts are lost.
- R7: A counter write loads the strobed bytes into the counter. Writing zero restarts the timeout, and this write takes priority over a step in the same cycle.
- R8: While the run flag is 0 the counter holds its value and no reset request starts.
- R9: When the running counter equals the limit, `wdg_rst_req` rises one clock later and stays high for exactly 4 clocks. The counter then stays at the limit, and a new request cannot start until the current one has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_we | input | 1 | Write request |
| bus_be | input | 2 | Byte write strobes |
| bus_addr | input | 4 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| tick_src | input | 3 | Tick strobes: bit 0 peripheral, bit 1 slow clock, bit 2 external |
| wdg_rst_req | output | 1 | System reset request pulse |

## Verification
The bench builds the block with its default parameters: 16-bit data, a 4-bit address, three tick sources, a largest divide code of 5 and a 4-clock request pulse. Small limit values keep even the divide-by-1024 timeouts to a few thousand ticks. That lets the bench walk all eight divide codes, including the two codes that saturate, and count every tick up to the request. The 4-clock pulse is short enough that its width and the counter hold after it are checked cycle by cycle.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam logic [1:0] IDX_LIMIT = 2'd0;
  localparam logic [1:0] IDX_RUN   = 2'd1;
  localparam logic [1:0] IDX_COUNT = 2'd2;
  localparam logic [1:0] IDX_CTRL  = 2'd3;

  localparam int SRC_N  = 3;
  localparam int CODE_W = 3;
  localparam int CTRL_W = SRC_N + CODE_W;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic [SRC_N-1:0]  src;
  } ctrl_t;
endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W/8-1:0] be,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] cnt,
  output logic [DATA_W-1:0] limit,
  output logic              run,
  output ctrl_t             ctrl,
  output logic              cnt_wr,
  output logic [DATA_W-1:0] cnt_wdata,
  output logic              div_clr,
  output logic [DATA_W-1:0] rdata
);
  localparam int NB = DATA_W / 8;

  logic [DATA_W-1:0] wmask;
  for (genvar b = 0; b < NB; b++) begin : g_mask
    assign wmask[b*8 +: 8] = {8{be[b]}};
  end

  logic       mapped;
  logic [1:0] widx;
  assign mapped = (addr[1:0] == 2'b00) && ((addr >> 4) == '0);
  assign widx   = addr[3:2];

  logic wr_hit;
  assign wr_hit = wr_en && mapped;

  always_ff @(posedge clk) begin
    if (rst) begin
      limit <= '0;
      run   <= 1'b0;
      ctrl  <= '0;
    end else if (wr_hit) begin
      case (widx)
        IDX_LIMIT: limit <= (limit & ~wmask) | (wdata & wmask);
        IDX_RUN:   if (be[0]) run <= wdata[0];
        IDX_CTRL:  if (be[0]) ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
        default: ;
      endcase
    end
  end

  assign cnt_wr    = wr_hit && (widx == IDX_COUNT) && (|be);
  assign cnt_wdata = (cnt & ~wmask) | (wdata & wmask);
  assign div_clr   = wr_hit && be[0] && ((widx == IDX_RUN) || (widx == IDX_CTRL));

  always_comb begin
    rdata = '0;
    if (mapped) begin
      case (widx)
        IDX_LIMIT: rdata = limit;
        IDX_RUN:   rdata = {{(DATA_W-1){1'b0}}, run};
        IDX_COUNT: rdata = cnt;
        IDX_CTRL:  rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl};
        default:   rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/wdg_prescaler.sv
module wdg_prescaler
  import wdg_pkg::*;
#(
  parameter int MAX_CODE = 5,
  parameter int STEP_LOG = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             clr,
  input  ctrl_t            ctrl,
  input  logic [SRC_N-1:0] tick_src,
  output logic             step
);
  localparam int DIV_W = (MAX_CODE * STEP_LOG > 0) ? MAX_CODE * STEP_LOG : 1;

  logic              sel_tick;
  logic [CODE_W-1:0] code_eff;
  logic [DIV_W-1:0]  div_cnt;
  logic [DIV_W-1:0]  div_last;
  int unsigned       shamt;

  assign sel_tick = |(tick_src & ctrl.src);

  always_comb begin
    code_eff = (int'(ctrl.code) > MAX_CODE) ? CODE_W'(MAX_CODE) : ctrl.code;
    shamt    = STEP_LOG * int'(code_eff);
    div_last = DIV_W'(((DIV_W+1)'(1) << shamt) - (DIV_W+1)'(1));
  end

  assign step = run && sel_tick && (div_cnt == div_last);

  always_ff @(posedge clk) begin
    if (rst || clr || !run) begin
      div_cnt <= '0;
    end else if (sel_tick) begin
      div_cnt <= (div_cnt == div_last) ? '0 : div_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
  parameter int CNT_W     = 16,
  parameter int PULSE_LEN = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             step,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt,
  output logic             hit,
  output logic             rst_req
);
  localparam int PW = $clog2(PULSE_LEN + 1);

  logic          hit_q;
  logic [PW-1:0] pulse_cnt;

  assign hit = run && (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (cnt_wr) begin
      cnt <= cnt_wdata;
    end else if (step && !hit) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q     <= 1'b0;
      pulse_cnt <= '0;
    end else begin
      hit_q <= hit;
      if (hit && !hit_q && (pulse_cnt == '0)) begin
        pulse_cnt <= PW'(PULSE_LEN);
      end else if (pulse_cnt != '0) begin
        pulse_cnt <= pulse_cnt - 1'b1;
      end
    end
  end

  assign rst_req = (pulse_cnt != '0);
endmodule

// File: rtl/wdg_top.sv
module wdg_top
  import wdg_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 4,
  parameter int MAX_CODE  = 5,
  parameter int STEP_LOG  = 2,
  parameter int PULSE_LEN = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_we,
  input  logic [DATA_W/8-1:0] bus_be,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [SRC_N-1:0]    tick_src,
  output logic                wdg_rst_req
);
  logic [DATA_W-1:0] limit, cnt, cnt_wdata;
  logic              run, cnt_wr, div_clr, step, hit;
  ctrl_t             ctrl;

  wdg_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_regs (
    .clk(clk), .rst(rst), .wr_en(bus_we), .be(bus_be), .addr(bus_addr),
    .wdata(bus_wdata), .cnt(cnt), .limit(limit), .run(run), .ctrl(ctrl),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .div_clr(div_clr), .rdata(bus_rdata)
  );

  wdg_prescaler #(.MAX_CODE(MAX_CODE), .STEP_LOG(STEP_LOG)) i_presc (
    .clk(clk), .rst(rst), .run(run), .clr(div_clr), .ctrl(ctrl),
    .tick_src(tick_src), .step(step)
  );

  wdg_counter #(.CNT_W(DATA_W), .PULSE_LEN(PULSE_LEN)) i_cnt (
    .clk(clk), .rst(rst), .run(run), .step(step), .cnt_wr(cnt_wr),
    .cnt_wdata(cnt_wdata), .limit(limit), .cnt(cnt), .hit(hit),
    .rst_req(wdg_rst_req)
  );
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker
  import wdg_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int PULSE_LEN = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              run,
  input logic              cnt_wr,
  input logic              hit,
  input logic [DATA_W-1:0] cnt,
  input logic [DATA_W-1:0] limit,
  input ctrl_t             ctrl,
  input logic              wdg_rst_req
);
  int unsigned hi_len;
  always_ff @(posedge clk) begin
    if (rst || !wdg_rst_req) hi_len <= 0;
    else hi_len <= hi_len + 1;
  end

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    wdg_rst_req |-> hi_len < PULSE_LEN); // R9
  AST_PULSE_AFTER_HIT: assert property (@(posedge clk) disable iff (rst)
    $rose(wdg_rst_req) |-> $past(hit)); // R9
  AST_HOLD_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (run && cnt == limit && !cnt_wr) |=> $stable(cnt)); // R9
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (rst)
    (!run && !cnt_wr) |=> $stable(cnt)); // R8
  AST_NO_SOURCE: assert property (@(posedge clk) disable iff (rst)
    (ctrl.src == '0 && !cnt_wr) |=> $stable(cnt)); // R4
  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
    !cnt_wr |=> (cnt == $past(cnt)) || (cnt == DATA_W'($past(cnt) + 1'b1))); // R5
endmodule

bind wdg_top wdg_checker #(.DATA_W(DATA_W), .PULSE_LEN(PULSE_LEN)) i_wdg_checker (
  .clk(clk), .rst(rst), .run(run), .cnt_wr(cnt_wr), .hit(hit), .cnt(cnt),
  .limit(limit), .ctrl(ctrl), .wdg_rst_req(wdg_rst_req)
);

// File: tb/test_wdg_top.sv
`timescale 1ns/1ps
module test_wdg_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_be = 2'b00;
  logic [3:0]  bus_addr = 4'h0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic [2:0]  tick_src = 3'b000;
  logic        wdg_rst_req;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  wdg_top i_wdg_top (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_be(bus_be), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_src(tick_src),
    .wdg_rst_req(wdg_rst_req)
  );

  localparam int NV = 8;
  localparam int VCODE [NV] = '{0, 1, 2, 3, 4, 5, 6, 7};
  localparam int VLIM  [NV] = '{5, 3, 2, 2, 1, 2, 1, 1};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_be = be; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_be = 2'b00;
  endtask

  task automatic rd(input logic [3:0] a, output int d);
    bus_addr = a;
    #1;
    d = int'(bus_rdata);
  endtask

  task automatic ticks(input logic [2:0] m, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_src = m;
      @(negedge clk); tick_src = 3'b000;
    end
  endtask

  task automatic prog(input int code, input int lim, input logic [2:0] src);
    wr(4'h4, 16'h0, 2'b01);
    wr(4'hC, 16'(code << 3), 2'b01);
    wr(4'h0, 16'(lim), 2'b11);
    wr(4'h8, 16'h0, 2'b11);
    wr(4'hC, 16'((code << 3) | int'(src)), 2'b01);
    wr(4'h4, 16'h1, 2'b01);
  endtask

  task automatic stop_and_settle();
    wr(4'h4, 16'h0, 2'b01);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int v, ratio, seen;
    repeat (4) @(negedge clk);
    // R1 reset state
    rd(4'h0, v); chk("R1 limit", v, 0);
    rd(4'h4, v); chk("R1 run", v, 0);
    rd(4'h8, v); chk("R1 count", v, 0);
    rd(4'hC, v); chk("R1 ctrl", v, 0);
    chk("R1 req", int'(wdg_rst_req), 0);
    rst = 1'b0;

    // table: timeout tick count per divide code (R5)
    for (int k = 0; k < NV; k++) begin
      ratio = (VCODE[k] > 5) ? 1024 : (1 << (2 * VCODE[k]));
      prog(VCODE[k], VLIM[k], 3'b001);
      ticks(3'b001, VLIM[k] * ratio - 1);
      rd(4'h8, v); chk("R5 count before last tick", v, VLIM[k] - 1);
      chk("R5 no req before timeout", int'(wdg_rst_req), 0);
      ticks(3'b001, 1);
      rd(4'h8, v); chk("R5 count at limit", v, VLIM[k]);
      @(negedge clk);
      chk("R9 req one clock after hit", int'(wdg_rst_req), 1);
      stop_and_settle();
    end

    // R2 readback, unused bits, unmapped address
    wr(4'hC, 16'hFFFF, 2'b11);
    rd(4'hC, v); chk("R2 ctrl unused bits zero", v, 16'h003F);
    wr(4'h4, 16'hFFFE, 2'b11);
    rd(4'h4, v); chk("R2 run bit0 only", v, 0);
    wr(4'h0, 16'h1234, 2'b11);
    wr(4'h2, 16'hFFFF, 2'b11);
    rd(4'h0, v); chk("R2 limit readback, unaligned write ignored", v, 16'h1234);
    rd(4'h2, v); chk("R2 unmapped reads zero", v, 0);
    // R3 byte strobes
    wr(4'h0, 16'hABCD, 2'b01);
    rd(4'h0, v); chk("R3 low byte only", v, 16'h12CD);
    wr(4'h0, 16'h5600, 2'b10);
    rd(4'h0, v); chk("R3 high byte only", v, 16'h56CD);
    wr(4'hC, 16'h0, 2'b11);

    // R4 source selection
    prog(0, 100, 3'b010);
    ticks(3'b101, 4);
    rd(4'h8, v); chk("R4 unselected sources ignored", v, 0);
    ticks(3'b010, 3);
    rd(4'h8, v); chk("R4 selected source counts", v, 3);
    prog(0, 100, 3'b000);
    ticks(3'b111, 5);
    rd(4'h8, v); chk("R4 no source, no count", v, 0);

    // R6 divider clear on control write
    prog(1, 100, 3'b001);
    ticks(3'b001, 3);
    wr(4'hC, 16'((1 << 3) | 1), 2'b01);
    ticks(3'b001, 3);
    rd(4'h8, v); chk("R6 divider cleared", v, 0);
    ticks(3'b001, 1);
    rd(4'h8, v); chk("R6 step after full ratio", v, 1);

    // R7 ping and load
    prog(0, 4, 3'b001);
    ticks(3'b001, 3);
    wr(4'h8, 16'h0, 2'b11);
    ticks(3'b001, 3);
    rd(4'h8, v); chk("R7 ping restarts count", v, 3);
    chk("R7 no req after ping", int'(wdg_rst_req), 0);
    // R9 pulse width and hold
    ticks(3'b001, 1);
    seen = 0;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (wdg_rst_req) seen++;
    end
    chk("R9 pulse width", seen, 4);
    ticks(3'b001, 3);
    rd(4'h8, v); chk("R9 counter holds at limit", v, 4);
    chk("R9 no second pulse", int'(wdg_rst_req), 0);
    wr(4'h8, 16'h0102, 2'b11);
    rd(4'h8, v); chk("R7 counter load", v, 16'h0102);
    stop_and_settle();

    // R8 stopped block
    prog(0, 2, 3'b001);
    wr(4'h4, 16'h0, 2'b01);
    seen = 0;
    for (int i = 0; i < 6; i++) begin
      ticks(3'b001, 1);
      if (wdg_rst_req) seen++;
    end
    rd(4'h8, v); chk("R8 count holds when stopped", v, 0);
    chk("R8 no request when stopped", seen, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule